// File: doc/BRIEF.md
# Triggered Single-Transaction Bus Bridge

This block lets a host processor run one read or one write at a time on a downstream peripheral bus, using a small word-addressed register file. Software first programs the direction, the transfer size, the target address and, for a write, the data. It then writes a 1 to the launch register. The bridge captures those settings and drives a valid/ready request downstream. It waits for a response coded as ack, error or retry, and reissues the same request on retry until a programmable retry limit is reached.

A cycle-count watchdog ends any attempt that draws no response. Every ending, good or bad, is recorded in a five-bit outcome word. Every ending also sets a sticky completion flag in the interrupt status register. The interrupt output is that flag gated by a mask bit, and writing the clear register drops the flag. Read results appear zero-extended in a read-data register. The block also holds two base-address registers and a channel-select bit as plain storage for software.

Top module: `txn_bridge`

## Requirements
- R1: After synchronous reset, the control base reads 0x80000000, the peripheral base reads 0xA0000000 and the retry limit reads 0x10. All other registers read 0, `irq` is low and no request is offered.
- R2: Writing a value with bit 0 set to offset 0x04 while idle starts a request in the next cycle. The request carries the programmed direction (offset 0x14 bit 0: 1 = read, 0 = write), size (offset 0x18 bits 1:0), address (0x1C) and write data (0x20). `dn_req_valid` and the request fields stay unchanged until `dn_req_ready` is seen or the watchdog fires.
- R3: An ack response (code 0) ends the transaction. The outcome word at offset 0x80 then holds bit 1 for size codes 2 and 3, or bit 0 for size codes 0 (byte) and 1 (halfword). Bit 16 of offset 0x48 is set.
- R4: On an acked read, offset 0x84 holds the response data masked to 8 bits for size 0, 16 bits for size 1 and 32 bits otherwise, with the upper bits zero. A write leaves it at 0.
- R5: An error response (code 1, and also code 3) ends the transaction with outcome word 0x04.
- R6: A retry response (code 2) reissues the identical request. It does so unless the number of retries received reaches the value at offset 0x64 (bits 7:0). In that case the transaction ends with outcome word 0x0C (retry and error).
- R7: If the watchdog count reaches WD_LIMIT busy cycles since launch or since the last reissue, and no response has arrived, the transaction ends with outcome word 0x10. Any pending request is withdrawn.
- R8: A launch write made while a transaction is busy has no effect: no further request is issued and the captured request does not change.
- R9: A launch clears the outcome word, the read data and the completion bit. After a transaction ends, these keep their values until the next launch. The one exception is that writing bit 0 set to offset 0x40 clears only the completion bit.
- R10: `irq` equals bit 16 of 0x48 ANDed with bit 16 of the mask at 0x44. Bit 17 of 0x48 always reads 0.
- R11: Every register reads back what was last written, limited to its field width. Offsets 0x08, 0x0C, 0x1C and 0x20 are 32 bits wide. Offsets 0x10 and 0x14 keep bit 0, 0x18 keeps bits 1:0, 0x64 keeps bits 7:0 and 0x44 keeps bits 17:16. Offsets 0x04 and 0x40 and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_addr | input | 8 | Host register byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for the register at `host_addr` |
| irq | output | 1 | Masked completion interrupt |
| dn_req_valid | output | 1 | Downstream request valid |
| dn_req_ready | input | 1 | Downstream request accepted |
| dn_req_write | output | 1 | 1 = write, 0 = read |
| dn_req_size | output | 2 | Transfer size code |
| dn_req_addr | output | 32 | Target address |
| dn_req_wdata | output | 32 | Write data |
| dn_rsp_valid | input | 1 | Response valid |
| dn_rsp_code | input | 2 | 0 ack, 1 error, 2 retry, 3 error |
| dn_rsp_rdata | input | 32 | Response read data |

## Verification
The bench covers retries that stop exactly at the limit. A design with an off-by-one comparison would issue one request too many or too few, and the handshake count would show it. Both watchdog paths are exercised: no ready at all, and ready with no response. A bridge that forgot to drop `valid` or to raise completion would hang, or would report an ack that never came. A second launch while busy, combined with an address change, exposes a design that relaunches or that samples live registers. A clear between transactions, and masked versus unmasked interrupts, show whether the outcome word is wrongly wiped or the interrupt wrongly gated.

// File: rtl/txn_bridge_pkg.sv
package txn_bridge_pkg;

    localparam int HOST_AW = 8;
    localparam int DATA_W  = 32;
    localparam int ST_W    = 5;

    localparam logic [HOST_AW-1:0] OFS_LAUNCH = 8'h04;
    localparam logic [HOST_AW-1:0] OFS_CBASE  = 8'h08;
    localparam logic [HOST_AW-1:0] OFS_PBASE  = 8'h0C;
    localparam logic [HOST_AW-1:0] OFS_CHSEL  = 8'h10;
    localparam logic [HOST_AW-1:0] OFS_DIR    = 8'h14;
    localparam logic [HOST_AW-1:0] OFS_SIZE   = 8'h18;
    localparam logic [HOST_AW-1:0] OFS_TADDR  = 8'h1C;
    localparam logic [HOST_AW-1:0] OFS_WDATA  = 8'h20;
    localparam logic [HOST_AW-1:0] OFS_ICLR   = 8'h40;
    localparam logic [HOST_AW-1:0] OFS_IMASK  = 8'h44;
    localparam logic [HOST_AW-1:0] OFS_ISTAT  = 8'h48;
    localparam logic [HOST_AW-1:0] OFS_RLIM   = 8'h64;
    localparam logic [HOST_AW-1:0] OFS_OUTC   = 8'h80;
    localparam logic [HOST_AW-1:0] OFS_RDATA  = 8'h84;

    localparam int IRQ_LSB = 16;

    localparam logic [ST_W-1:0] OUT_SUB_ACK  = 5'b00001;
    localparam logic [ST_W-1:0] OUT_WORD_ACK = 5'b00010;
    localparam logic [ST_W-1:0] OUT_ERR      = 5'b00100;
    localparam logic [ST_W-1:0] OUT_RETRY    = 5'b01000;
    localparam logic [ST_W-1:0] OUT_TMO      = 5'b10000;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_RSVD = 2'd2,
        SZ_WORD = 2'd3
    } xfer_size_e;

    typedef enum logic [1:0] {
        RSP_ACK   = 2'd0,
        RSP_ERR   = 2'd1,
        RSP_RETRY = 2'd2,
        RSP_BAD   = 2'd3
    } rsp_code_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_REQ,
        PH_WAIT
    } phase_e;

    typedef struct packed {
        logic              write;
        xfer_size_e        size;
        logic [DATA_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } xfer_cmd_t;

    function automatic logic [DATA_W-1:0] fit_read(input logic [DATA_W-1:0] d,
                                                   input xfer_size_e s);
        logic [DATA_W-1:0] r;
        case (s)
            SZ_BYTE: r = {{(DATA_W-8){1'b0}}, d[7:0]};
            SZ_HALF: r = {{(DATA_W-16){1'b0}}, d[15:0]};
            default: r = d;
        endcase
        return r;
    endfunction

    function automatic logic [ST_W-1:0] ack_outcome(input xfer_size_e s);
        return s[1] ? OUT_WORD_ACK : OUT_SUB_ACK;
    endfunction

endpackage

// File: rtl/txn_bridge_wdog.sv
module txn_bridge_wdog #(
    parameter int LIMIT = 64,
    localparam int CW   = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic step,
    output logic expired
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (step && !expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = (cnt_q == CW'(LIMIT - 1));

endmodule

// File: rtl/txn_bridge_regs.sv
module txn_bridge_regs
    import txn_bridge_pkg::*;
#(
    parameter int                RL_W      = 8,
    parameter logic [DATA_W-1:0] CBASE_RST = 32'h8000_0000,
    parameter logic [DATA_W-1:0] PBASE_RST = 32'hA000_0000,
    parameter logic [RL_W-1:0]   RLIM_RST  = 8'h10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_wr_en,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [DATA_W-1:0]  host_wdata,
    output logic [DATA_W-1:0]  host_rdata,
    input  logic [ST_W-1:0]    outcome,
    input  logic [DATA_W-1:0]  rd_result,
    input  logic               done,
    output xfer_cmd_t          cmd,
    output logic [RL_W-1:0]    retry_limit,
    output logic [1:0]         irq_mask,
    output logic               launch_req,
    output logic               clear_req
);
    logic [DATA_W-1:0] cbase_q, pbase_q, taddr_q, wdata_q;
    logic              chsel_q, dir_q;
    logic [1:0]        size_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cbase_q     <= CBASE_RST;
            pbase_q     <= PBASE_RST;
            taddr_q     <= '0;
            wdata_q     <= '0;
            chsel_q     <= 1'b0;
            dir_q       <= 1'b0;
            size_q      <= 2'd0;
            retry_limit <= RLIM_RST;
            irq_mask    <= 2'd0;
        end else if (host_wr_en) begin
            case (host_addr)
                OFS_CBASE: cbase_q     <= host_wdata;
                OFS_PBASE: pbase_q     <= host_wdata;
                OFS_TADDR: taddr_q     <= host_wdata;
                OFS_WDATA: wdata_q     <= host_wdata;
                OFS_CHSEL: chsel_q     <= host_wdata[0];
                OFS_DIR:   dir_q       <= host_wdata[0];
                OFS_SIZE:  size_q      <= host_wdata[1:0];
                OFS_RLIM:  retry_limit <= host_wdata[RL_W-1:0];
                OFS_IMASK: irq_mask    <= host_wdata[IRQ_LSB+1:IRQ_LSB];
                default:   ;
            endcase
        end
    end

    assign launch_req = host_wr_en && (host_addr == OFS_LAUNCH) && host_wdata[0];
    assign clear_req  = host_wr_en && (host_addr == OFS_ICLR) && host_wdata[0];

    always_comb begin
        cmd.write = !dir_q;
        cmd.size  = xfer_size_e'(size_q);
        cmd.addr  = taddr_q;
        cmd.wdata = wdata_q;
    end

    always_comb begin
        host_rdata = '0;
        case (host_addr)
            OFS_CBASE: host_rdata = cbase_q;
            OFS_PBASE: host_rdata = pbase_q;
            OFS_TADDR: host_rdata = taddr_q;
            OFS_WDATA: host_rdata = wdata_q;
            OFS_CHSEL: host_rdata[0] = chsel_q;
            OFS_DIR:   host_rdata[0] = dir_q;
            OFS_SIZE:  host_rdata[1:0] = size_q;
            OFS_RLIM:  host_rdata[RL_W-1:0] = retry_limit;
            OFS_IMASK: host_rdata[IRQ_LSB+1:IRQ_LSB] = irq_mask;
            OFS_ISTAT: host_rdata[IRQ_LSB] = done;
            OFS_OUTC:  host_rdata[ST_W-1:0] = outcome;
            OFS_RDATA: host_rdata = rd_result;
            default:   host_rdata = '0;
        endcase
    end

endmodule

// File: rtl/txn_bridge_engine.sv
module txn_bridge_engine
    import txn_bridge_pkg::*;
#(
    parameter int RL_W     = 8,
    parameter int WD_LIMIT = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch_req,
    input  logic              clear_req,
    input  xfer_cmd_t         cmd_in,
    input  logic [RL_W-1:0]   retry_limit,
    output logic              dn_req_valid,
    input  logic              dn_req_ready,
    output logic              dn_req_write,
    output logic [1:0]        dn_req_size,
    output logic [DATA_W-1:0] dn_req_addr,
    output logic [DATA_W-1:0] dn_req_wdata,
    input  logic              dn_rsp_valid,
    input  logic [1:0]        dn_rsp_code,
    input  logic [DATA_W-1:0] dn_rsp_rdata,
    output logic [ST_W-1:0]   outcome,
    output logic [DATA_W-1:0] rd_result,
    output logic              done,
    output logic              busy
);
    phase_e          phase_q;
    xfer_cmd_t       cmd_q;
    logic [RL_W-1:0] rtry_q;
    logic [RL_W:0]   rtry_next;
    logic            rsp_take, is_retry, wd_restart, wd_expired;
    rsp_code_e       code;

    assign code      = rsp_code_e'(dn_rsp_code);
    assign busy      = (phase_q != PH_IDLE);
    assign rsp_take  = (phase_q == PH_WAIT) && dn_rsp_valid;
    assign is_retry  = rsp_take && (code == RSP_RETRY);
    assign rtry_next = {1'b0, rtry_q} + 1'b1;
    assign wd_restart = !busy || (is_retry && (rtry_next < {1'b0, retry_limit}));

    txn_bridge_wdog #(.LIMIT(WD_LIMIT)) u_wdog (
        .clk     (clk),
        .rst     (rst),
        .restart (wd_restart),
        .step    (busy),
        .expired (wd_expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_IDLE;
            cmd_q     <= '0;
            rtry_q    <= '0;
            outcome   <= '0;
            rd_result <= '0;
            done      <= 1'b0;
        end else begin
            if (clear_req) done <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (launch_req) begin
                        phase_q   <= PH_REQ;
                        cmd_q     <= cmd_in;
                        rtry_q    <= '0;
                        outcome   <= '0;
                        rd_result <= '0;
                        done      <= 1'b0;
                    end
                end
                default: begin
                    if (rsp_take) begin
                        case (code)
                            RSP_ACK: begin
                                outcome <= ack_outcome(cmd_q.size);
                                if (!cmd_q.write)
                                    rd_result <= fit_read(dn_rsp_rdata, cmd_q.size);
                                phase_q <= PH_IDLE;
                                done    <= 1'b1;
                            end
                            RSP_RETRY: begin
                                if (rtry_next >= {1'b0, retry_limit}) begin
                                    outcome <= OUT_RETRY | OUT_ERR;
                                    phase_q <= PH_IDLE;
                                    done    <= 1'b1;
                                end else begin
                                    rtry_q  <= rtry_next[RL_W-1:0];
                                    phase_q <= PH_REQ;
                                end
                            end
                            default: begin
                                outcome <= OUT_ERR;
                                phase_q <= PH_IDLE;
                                done    <= 1'b1;
                            end
                        endcase
                    end else if (wd_expired) begin
                        outcome <= OUT_TMO;
                        phase_q <= PH_IDLE;
                        done    <= 1'b1;
                    end else if (phase_q == PH_REQ && dn_req_ready) begin
                        phase_q <= PH_WAIT;
                    end
                end
            endcase
        end
    end

    assign dn_req_valid = (phase_q == PH_REQ);
    assign dn_req_write = cmd_q.write;
    assign dn_req_size  = cmd_q.size;
    assign dn_req_addr  = cmd_q.addr;
    assign dn_req_wdata = cmd_q.wdata;

    p_hold_valid_r2: assert property (@(posedge clk) disable iff (rst)
        (dn_req_valid && !dn_req_ready) |=> (dn_req_valid || done));

    p_hold_addr_r2: assert property (@(posedge clk) disable iff (rst)
        (dn_req_valid && !dn_req_ready) |=> $stable(dn_req_addr));

    p_end_has_outcome_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (outcome != '0));

    p_timeout_alone_r7: assert property (@(posedge clk) disable iff (rst)
        outcome[4] |-> (outcome[3:0] == 4'd0));

    p_busy_launch_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && launch_req && !dn_req_valid) |=> $stable(dn_req_size));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!busy && !launch_req) |=> ($stable(outcome) && $stable(rd_result)));

    p_launch_clears_r9: assert property (@(posedge clk) disable iff (rst)
        (launch_req && !busy) |=> (outcome == '0 && !done && dn_req_valid));

endmodule

// File: rtl/txn_bridge.sv
module txn_bridge
    import txn_bridge_pkg::*;
#(
    parameter int RL_W     = 8,
    parameter int WD_LIMIT = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_wr_en,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [DATA_W-1:0]  host_wdata,
    output logic [DATA_W-1:0]  host_rdata,
    output logic               irq,
    output logic               dn_req_valid,
    input  logic               dn_req_ready,
    output logic               dn_req_write,
    output logic [1:0]         dn_req_size,
    output logic [DATA_W-1:0]  dn_req_addr,
    output logic [DATA_W-1:0]  dn_req_wdata,
    input  logic               dn_rsp_valid,
    input  logic [1:0]         dn_rsp_code,
    input  logic [DATA_W-1:0]  dn_rsp_rdata
);
    xfer_cmd_t         cmd;
    logic [RL_W-1:0]   retry_limit;
    logic [1:0]        irq_mask;
    logic              launch_req, clear_req, done, busy;
    logic [ST_W-1:0]   outcome;
    logic [DATA_W-1:0] rd_result;

    txn_bridge_regs #(.RL_W(RL_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .host_wr_en  (host_wr_en),
        .host_addr   (host_addr),
        .host_wdata  (host_wdata),
        .host_rdata  (host_rdata),
        .outcome     (outcome),
        .rd_result   (rd_result),
        .done        (done),
        .cmd         (cmd),
        .retry_limit (retry_limit),
        .irq_mask    (irq_mask),
        .launch_req  (launch_req),
        .clear_req   (clear_req)
    );

    txn_bridge_engine #(.RL_W(RL_W), .WD_LIMIT(WD_LIMIT)) u_engine (
        .clk          (clk),
        .rst          (rst),
        .launch_req   (launch_req),
        .clear_req    (clear_req),
        .cmd_in       (cmd),
        .retry_limit  (retry_limit),
        .dn_req_valid (dn_req_valid),
        .dn_req_ready (dn_req_ready),
        .dn_req_write (dn_req_write),
        .dn_req_size  (dn_req_size),
        .dn_req_addr  (dn_req_addr),
        .dn_req_wdata (dn_req_wdata),
        .dn_rsp_valid (dn_rsp_valid),
        .dn_rsp_code  (dn_rsp_code),
        .dn_rsp_rdata (dn_rsp_rdata),
        .outcome      (outcome),
        .rd_result    (rd_result),
        .done         (done),
        .busy         (busy)
    );

    assign irq = done && irq_mask[0];

    p_irq_follows_done_r10: assert property (@(posedge clk) disable iff (rst)
        irq |-> (done && !busy));

endmodule

// File: tb/txn_bridge_test.sv
module txn_bridge_test;

    localparam int WD = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr_en = 1'b0;
    logic [7:0]  host_addr = 8'h48;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        irq;
    logic        dn_req_valid, dn_req_write;
    logic        dn_req_ready = 1'b0;
    logic [1:0]  dn_req_size;
    logic [31:0] dn_req_addr, dn_req_wdata;
    logic        dn_rsp_valid = 1'b0;
    logic [1:0]  dn_rsp_code = 2'd0;
    logic [31:0] dn_rsp_rdata = '0;

    always #2.5 clk = ~clk;

    txn_bridge #(.WD_LIMIT(WD)) uut (
        .clk(clk), .rst(rst),
        .host_wr_en(host_wr_en), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq),
        .dn_req_valid(dn_req_valid), .dn_req_ready(dn_req_ready),
        .dn_req_write(dn_req_write), .dn_req_size(dn_req_size),
        .dn_req_addr(dn_req_addr), .dn_req_wdata(dn_req_wdata),
        .dn_rsp_valid(dn_rsp_valid), .dn_rsp_code(dn_rsp_code),
        .dn_rsp_rdata(dn_rsp_rdata)
    );

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    bit          r_dir, r_sel;
    logic [1:0]  r_size, r_mask;
    logic [31:0] r_addr, r_wdata, r_cb, r_pb;
    logic [7:0]  r_lim;
    bit          m_busy, m_done, m_write;
    int          m_phase, m_wd, m_retries;
    logic [1:0]  m_size;
    logic [31:0] m_addr, m_wdata, m_rdata;
    logic [4:0]  m_status;

    always @(posedge clk) begin
        bit launch_now, clear_now, fin;
        if (rst) begin
            r_dir = 0; r_sel = 0; r_size = 0; r_mask = 0;
            r_addr = 0; r_wdata = 0; r_cb = 32'h8000_0000; r_pb = 32'hA000_0000;
            r_lim = 8'h10;
            m_busy = 0; m_done = 0; m_write = 0; m_phase = 0; m_wd = 0; m_retries = 0;
            m_size = 0; m_addr = 0; m_wdata = 0; m_rdata = 0; m_status = 0;
        end else begin
            launch_now = host_wr_en && host_addr == 8'h04 && host_wdata[0] && !m_busy;
            clear_now  = host_wr_en && host_addr == 8'h40 && host_wdata[0];
            fin = 0;
            if (clear_now) m_done = 0;
            if (m_busy) begin
                if (m_phase == 1 && dn_rsp_valid) begin
                    if (dn_rsp_code == 2'd0) begin
                        m_status = m_size[1] ? 5'h02 : 5'h01;
                        if (!m_write)
                            m_rdata = (m_size == 2'd0) ? (dn_rsp_rdata & 32'hFF) :
                                      (m_size == 2'd1) ? (dn_rsp_rdata & 32'hFFFF) : dn_rsp_rdata;
                        fin = 1;
                    end else if (dn_rsp_code == 2'd2) begin
                        if (m_retries + 1 >= int'(r_lim)) begin
                            m_status = 5'h0C; fin = 1;
                        end else begin
                            m_retries++; m_wd = 0; m_phase = 0;
                        end
                    end else begin
                        m_status = 5'h04; fin = 1;
                    end
                end else if (m_wd == WD - 1) begin
                    m_status = 5'h10; fin = 1;
                end else begin
                    m_wd++;
                    if (m_phase == 0 && dn_req_ready) m_phase = 1;
                end
                if (fin) begin m_busy = 0; m_done = 1; end
            end else if (launch_now) begin
                m_write = !r_dir; m_size = r_size; m_addr = r_addr; m_wdata = r_wdata;
                m_busy = 1; m_phase = 0; m_wd = 0; m_retries = 0;
                m_status = 0; m_rdata = 0; m_done = 0;
            end
            if (host_wr_en) begin
                case (host_addr)
                    8'h08: r_cb = host_wdata;
                    8'h0C: r_pb = host_wdata;
                    8'h10: r_sel = host_wdata[0];
                    8'h14: r_dir = host_wdata[0];
                    8'h18: r_size = host_wdata[1:0];
                    8'h1C: r_addr = host_wdata;
                    8'h20: r_wdata = host_wdata;
                    8'h44: r_mask = host_wdata[17:16];
                    8'h64: r_lim = host_wdata[7:0];
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] model_read(input logic [7:0] a);
        case (a)
            8'h08: return r_cb;
            8'h0C: return r_pb;
            8'h10: return {31'd0, r_sel};
            8'h14: return {31'd0, r_dir};
            8'h18: return {30'd0, r_size};
            8'h1C: return r_addr;
            8'h20: return r_wdata;
            8'h44: return {14'd0, r_mask, 16'd0};
            8'h48: return {15'd0, m_done, 16'd0};
            8'h64: return {24'd0, r_lim};
            8'h80: return {27'd0, m_status};
            8'h84: return m_rdata;
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'h80: return "R3 R5 R6 R7 outcome";
            8'h84: return "R4 read data";
            8'h48: return "R9 completion";
            default: return "R11 readback";
        endcase
    endfunction

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk(dn_req_valid === (m_busy && m_phase == 0), "R2 R8 request valid",
                {31'd0, dn_req_valid}, {31'd0, m_busy && m_phase == 0});
            if (dn_req_valid && m_busy) begin
                chk(dn_req_write === m_write && dn_req_size === m_size,
                    "R2 request kind", {29'd0, dn_req_write, dn_req_size},
                    {29'd0, m_write, m_size});
                chk(dn_req_addr === m_addr, "R2 request addr", dn_req_addr, m_addr);
                chk(dn_req_wdata === m_wdata, "R2 request data", dn_req_wdata, m_wdata);
            end
            chk(irq === (m_done && r_mask[0]), "R10 irq",
                {31'd0, irq}, {31'd0, m_done && r_mask[0]});
            chk(host_rdata === model_read(host_addr), tag_of(host_addr),
                host_rdata, model_read(host_addr));
        end
    end

    // Downstream responder
    int          ready_lat = 1;
    int          rsp_lat = 2;
    int          rsp_q[$];
    logic [31:0] rsp_data = 32'h0;
    int          r_st = 0;
    int          r_cnt = 0;
    int          hs_cnt = 0;

    always @(negedge clk) begin
        #1;
        dn_req_ready = 1'b0;
        dn_rsp_valid = 1'b0;
        dn_rsp_code  = 2'd0;
        if (rst) begin
            r_st = 0; r_cnt = 0;
        end else begin
            if (r_st == 1 && dn_req_valid) begin r_st = 0; r_cnt = 0; end
            if (r_st == 0) begin
                if (dn_req_valid) begin
                    if (r_cnt >= ready_lat) begin
                        dn_req_ready = 1'b1; r_st = 1; r_cnt = 0; hs_cnt++;
                    end else r_cnt++;
                end else r_cnt = 0;
            end else begin
                if (rsp_q.size() > 0 && r_cnt >= rsp_lat) begin
                    dn_rsp_valid = 1'b1;
                    dn_rsp_code  = 2'(rsp_q.pop_front());
                    dn_rsp_rdata = rsp_data;
                    r_st = 0; r_cnt = 0;
                end else r_cnt++;
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        host_wr_en = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk); #1;
        host_wr_en = 1'b0; host_addr = 8'h48;
    endtask

    task automatic expect_reg(input logic [7:0] a, input logic [31:0] e, input string tag);
        @(negedge clk); #1;
        host_addr = a;
        #1;
        chk(host_rdata === e, tag, host_rdata, e);
    endtask

    task automatic wait_idle();
        int n = 0;
        @(negedge clk);
        while (m_busy && n < 500) begin @(negedge clk); n++; end
        @(negedge clk);
    endtask

    task automatic run(input int code);
        rsp_q.push_back(code);
        wr(8'h04, 32'h1);
        wait_idle();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog R2 act=hung exp=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : stim
        int h0;
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;

        // R1 reset values
        expect_reg(8'h08, 32'h8000_0000, "R1 control base");
        expect_reg(8'h0C, 32'hA000_0000, "R1 peripheral base");
        expect_reg(8'h64, 32'h10, "R1 retry limit");
        expect_reg(8'h80, 32'h0, "R1 outcome");
        expect_reg(8'h48, 32'h0, "R1 completion");
        chk(irq === 1'b0 && dn_req_valid === 1'b0, "R1 outputs idle",
            {30'd0, irq, dn_req_valid}, 32'd0);

        wr(8'h44, 32'h0001_0000);

        // R2 R3 full word write
        wr(8'h14, 0); wr(8'h18, 3);
        wr(8'h1C, 32'hA000_0010); wr(8'h20, 32'hDEAD_BEEF);
        run(0);
        expect_reg(8'h80, 32'h2, "R3 word ack");
        expect_reg(8'h48, 32'h0001_0000, "R3 completion set");
        chk(irq === 1'b1, "R10 irq raised", {31'd0, irq}, 32'd1);
        expect_reg(8'h84, 32'h0, "R4 write leaves read data zero");

        // R4 sized reads
        rsp_data = 32'hA5C3_1F77;
        wr(8'h14, 1); wr(8'h18, 0);
        run(0);
        expect_reg(8'h80, 32'h1, "R3 byte ack");
        expect_reg(8'h84, 32'h77, "R4 byte read");
        wr(8'h18, 1);
        run(0);
        expect_reg(8'h84, 32'h1F77, "R4 halfword read");
        wr(8'h18, 2);
        run(0);
        expect_reg(8'h80, 32'h2, "R3 size 2 ack");
        wr(8'h18, 3);
        run(0);
        expect_reg(8'h84, 32'hA5C3_1F77, "R4 word read");

        // R5 error codes
        run(1);
        expect_reg(8'h80, 32'h4, "R5 error");
        expect_reg(8'h84, 32'h0, "R9 launch cleared read data");
        run(3);
        expect_reg(8'h80, 32'h4, "R5 code 3 error");

        // R6 retries
        wr(8'h64, 3);
        h0 = hs_cnt;
        rsp_q.push_back(2); rsp_q.push_back(2);
        run(0);
        expect_reg(8'h80, 32'h2, "R6 ack after two retries");
        chk(hs_cnt - h0 == 3, "R6 request count below limit", hs_cnt - h0, 3);
        h0 = hs_cnt;
        rsp_q.push_back(2); rsp_q.push_back(2);
        run(2);
        expect_reg(8'h80, 32'h0C, "R6 retry limit reached");
        chk(hs_cnt - h0 == 3, "R6 request count at limit", hs_cnt - h0, 3);

        // R7 watchdog: accepted but silent, then never accepted
        wr(8'h04, 1); wait_idle();
        expect_reg(8'h80, 32'h10, "R7 timeout waiting response");
        ready_lat = 1000;
        wr(8'h04, 1); wait_idle();
        expect_reg(8'h80, 32'h10, "R7 timeout waiting ready");
        chk(dn_req_valid === 1'b0, "R7 request withdrawn", {31'd0, dn_req_valid}, 0);
        ready_lat = 1;

        // R8 launch while busy
        rsp_lat = 10;
        h0 = hs_cnt;
        rsp_q.push_back(0);
        wr(8'h04, 1);
        wr(8'h1C, 32'h1234_5678);
        wr(8'h04, 1);
        wait_idle();
        chk(hs_cnt - h0 == 1, "R8 single request", hs_cnt - h0, 1);
        expect_reg(8'h80, 32'h2, "R8 first transaction result");
        rsp_lat = 2;

        // R9 clear and hold
        wr(8'h40, 1);
        expect_reg(8'h48, 32'h0, "R9 clear drops completion");
        expect_reg(8'h80, 32'h2, "R9 outcome held after clear");
        expect_reg(8'h84, 32'hA5C3_1F77, "R9 read data held");
        chk(irq === 1'b0, "R10 irq low after clear", {31'd0, irq}, 0);

        // R10 masked
        wr(8'h44, 0);
        run(0);
        expect_reg(8'h48, 32'h0001_0000, "R10 completion with mask off");
        chk(irq === 1'b0, "R10 irq masked", {31'd0, irq}, 0);

        // R11 readback widths
        wr(8'h10, 32'hFFFF_FFFF);
        expect_reg(8'h10, 32'h1, "R11 channel select");
        wr(8'h44, 32'hFFFF_FFFF);
        expect_reg(8'h44, 32'h0003_0000, "R11 mask field");
        expect_reg(8'h48, 32'h0001_0000, "R10 bit 17 stays zero");
        wr(8'h64, 32'hFFFF_FF05);
        expect_reg(8'h64, 32'h05, "R11 retry limit field");
        wr(8'h08, 32'h1357_9BDF);
        expect_reg(8'h08, 32'h1357_9BDF, "R11 control base");
        expect_reg(8'h04, 32'h0, "R11 launch reads zero");
        expect_reg(8'h1C, 32'h1234_5678, "R11 target address");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule